// File: doc/BRIEF.md
# Four-Slot Bank Address Translator for a Dual-CPU Machine

This block turns the 16-bit addresses of two CPUs into physical chip accesses. Each CPU's space is cut into four 16K slots by its top two address bits. The lowest slot always reaches that CPU's own local RAM, which holds its zero page, stack and device page. The second slot reaches either local RAM or a banked window into common RAM, chosen by one control bit. The third slot is always a second banked common RAM window. The top slot is banked flash ROM.

Each CPU owns two control bytes. They hold its ROM bank, its two common RAM bank bases and the local/common switch for the second slot. A third byte, the master byte, can only be written by CPU 0. For each CPU it picks which of the four 512K common RAM chips the windows land in, and it supplies the upper ROM address bits. CPU 1's topmost ROM bit is wired to one, so CPU 1 always sees the upper half of the flash.

The translation is combinational from the address and the registered control bytes. A control write becomes visible on the cycle after the clock edge that captures it. Arbitration between the CPUs and the memories themselves sit outside this block.

Top module: `slot_xlat`

## Requirements
- R1: After reset all control bytes are zero. The second slot then selects local RAM, and every bank base and chip select field is 0.
- R2: Addresses 0x0000-0x3FFF assert only the local RAM select (chip_sel bit 0). The physical address is address bits [14:0].
- R3: Addresses 0x4000-0x7FFF depend on bit 7 of the CPU's second control byte. If that bit is 0, they reach local RAM at address bits [14:0]. If it is 1, they reach the common chip chosen by the master byte, at {first byte bits [4:0], address bits [13:0]}.
- R4: Addresses 0x8000-0xBFFF reach the common chip chosen by the master byte, at {second byte bits [4:0], address bits [13:0]}. Common chip n is chip_sel bit 1+n.
- R5: For CPU 0, addresses 0xC000-0xFFFF assert only the ROM select (chip_sel bit 5). The physical address is {master bits [5:4], first byte bits [7:5], address bits [13:0]}.
- R6: For CPU 1, the ROM physical address is {1, master bit 6, first byte bits [7:5], address bits [13:0]}. Its top bit is always 1.
- R7: Master byte bits [1:0] pick CPU 0's common chip and bits [3:2] pick CPU 1's. Only CPU 0 can write the master byte. A master write from CPU 1 and any write with register code 3 change nothing.
- R8: A write uses register code 0 for the first byte and 1 for the second. It takes effect only after the capturing clock edge, and it changes only the writing CPU's bytes.
- R9: For every address, each CPU asserts exactly one chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2x16 | CPU address, one per CPU |
| cpu_wr | input | 2 | Control byte write strobe, one per CPU |
| cpu_reg | input | 2x2 | Register code: 0 first byte, 1 second byte, 2 master, 3 none |
| cpu_wdata | input | 2x8 | Control byte write data |
| chip_sel | output | 2x6 | One-hot select: bit 0 local, bits 1-4 common chips, bit 5 ROM |
| phys_addr | output | 2x19 | Address inside the selected chip |

## Verification
The bench sweeps every common chip value and every bank base, with the slot-1 switch alternating. It drives addresses across all four slots and both CPUs, so a swapped chip field between CPUs or a base taken from the wrong byte shows up as a wrong select or address. CPU 1's forced ROM bit is checked against a master byte that holds both values of bit 6. A translator that passed the master's upper bits straight through would give CPU 1 addresses in the lower flash half. Writes are sampled before and after the capturing edge to catch a write path that is combinational or lands a cycle late. A master write from CPU 1 and a code-3 write are each followed by a full re-check, which catches a design that lets the second CPU corrupt the shared byte.

// File: rtl/slot_xlat_pkg.sv
package slot_xlat_pkg;
   localparam int NCPU = 2;

   typedef enum logic [1:0] {
      REG_BANK_A = 2'd0,
      REG_BANK_B = 2'd1,
      REG_MASTER = 2'd2,
      REG_NONE   = 2'd3
   } reg_code_e;

   typedef enum logic [1:0] {
      SLOT_LOW  = 2'd0,
      SLOT_FLEX = 2'd1,
      SLOT_HIGH = 2'd2,
      SLOT_ROM  = 2'd3
   } slot_e;

   localparam int CS_LOCAL  = 0;
   localparam int CS_COMMON = 1;
endpackage

// File: rtl/slot_bank_regs.sv
module slot_bank_regs
   import slot_xlat_pkg::*;
#(
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [1:0]        code,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] bank_a,
   output logic [CTRL_W-1:0] bank_b
);
   logic hit_a, hit_b;

   assign hit_a = wr && (reg_code_e'(code) == REG_BANK_A);
   assign hit_b = wr && (reg_code_e'(code) == REG_BANK_B);

   always_ff @(posedge clk) begin
      if (rst) begin
         bank_a <= '0;
         bank_b <= '0;
      end else begin
         if (hit_a) bank_a <= wdata;
         if (hit_b) bank_b <= wdata;
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (bank_a == '0 && bank_b == '0));

   p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
      (wr && code == 2'd0) |=> (bank_a == $past(wdata)));

   p_unaddressed_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!wr || code[1]) |=> ($stable(bank_a) && $stable(bank_b)));
endmodule

// File: rtl/slot_master_reg.sv
module slot_master_reg
   import slot_xlat_pkg::*;
#(
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              own_wr,
   input  logic [1:0]        own_code,
   input  logic [CTRL_W-1:0] own_wdata,
   input  logic              other_wr,
   input  logic [1:0]        other_code,
   output logic [CTRL_W-1:0] master
);
   logic own_hit;

   assign own_hit = own_wr && (reg_code_e'(own_code) == REG_MASTER);

   always_ff @(posedge clk) begin
      if (rst)          master <= '0;
      else if (own_hit) master <= own_wdata;
   end

   p_reset_master_r1: assert property (@(posedge clk)
      rst |=> (master == '0));

   p_foreign_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
      (other_wr && other_code == 2'd2 && !(own_wr && own_code == 2'd2))
      |=> $stable(master));
endmodule

// File: rtl/slot_decode.sv
module slot_decode
   import slot_xlat_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CTRL_W     = 8,
   parameter int BASE_W     = 5,
   parameter int ROM_BASE_W = 3,
   parameter int CHIP_W     = 2,
   parameter int ROM_TOP_W  = 2,
   parameter int PHYS_W     = 19,
   parameter int CS_W       = 6,
   parameter bit FORCE_TOP  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [CTRL_W-1:0]    bank_a,
   input  logic [CTRL_W-1:0]    bank_b,
   input  logic [CHIP_W-1:0]    chip,
   input  logic [ROM_TOP_W-1:0] rom_top,
   output logic [CS_W-1:0]      cs,
   output logic [PHYS_W-1:0]    phys
);
   localparam int OFFS_W = ADDR_W - 2;
   localparam int CS_ROM = CS_W - 1;

   logic [OFFS_W-1:0]    offs;
   logic [OFFS_W:0]      local_addr;
   logic [BASE_W-1:0]    ram1_base, ram2_base;
   logic [ROM_BASE_W-1:0] rom_base;
   logic                 flex_common;
   logic [ROM_TOP_W-1:0] top_eff;
   slot_e                slot;

   assign slot        = slot_e'(addr[ADDR_W-1 -: 2]);
   assign offs        = addr[OFFS_W-1:0];
   assign local_addr  = addr[OFFS_W:0];
   assign ram1_base   = bank_a[BASE_W-1:0];
   assign rom_base    = bank_a[CTRL_W-1 -: ROM_BASE_W];
   assign ram2_base   = bank_b[BASE_W-1:0];
   assign flex_common = bank_b[CTRL_W-1];

   generate
      if (FORCE_TOP) begin : g_tied_top
         assign top_eff = {1'b1, rom_top[ROM_TOP_W-2:0]};
      end else begin : g_free_top
         assign top_eff = rom_top;
      end
   endgenerate

   always_comb begin
      cs   = '0;
      phys = '0;
      unique case (slot)
         SLOT_LOW: begin
            cs[CS_LOCAL] = 1'b1;
            phys         = PHYS_W'(local_addr);
         end
         SLOT_FLEX: begin
            if (flex_common) begin
               cs[CS_COMMON + int'(chip)] = 1'b1;
               phys = PHYS_W'({ram1_base, offs});
            end else begin
               cs[CS_LOCAL] = 1'b1;
               phys         = PHYS_W'(local_addr);
            end
         end
         SLOT_HIGH: begin
            cs[CS_COMMON + int'(chip)] = 1'b1;
            phys = PHYS_W'({ram2_base, offs});
         end
         SLOT_ROM: begin
            cs[CS_ROM] = 1'b1;
            phys       = PHYS_W'({top_eff, rom_base, offs});
         end
         default: ;
      endcase
   end

   p_one_select_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot(cs));

   p_low_slot_local_r2: assert property (@(posedge clk) disable iff (rst)
      (addr[ADDR_W-1 -: 2] == 2'd0) |-> (cs[CS_LOCAL] && !cs[CS_ROM]));

   p_high_slot_common_r4: assert property (@(posedge clk) disable iff (rst)
      (addr[ADDR_W-1 -: 2] == 2'd2) |-> (!cs[CS_LOCAL] && !cs[CS_ROM]));

   p_rom_slot_r5: assert property (@(posedge clk) disable iff (rst)
      (addr[ADDR_W-1 -: 2] == 2'd3) |-> (cs[CS_ROM] && phys[OFFS_W-1:0] == addr[OFFS_W-1:0]));
endmodule

// File: rtl/slot_xlat.sv
module slot_xlat
   import slot_xlat_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CTRL_W     = 8,
   parameter int BASE_W     = 5,
   parameter int ROM_BASE_W = 3,
   parameter int CHIP_W     = 2,
   parameter int ROM_TOP_W  = 2,
   localparam int OFFS_W    = ADDR_W - 2,
   localparam int COMMON_AW = BASE_W + OFFS_W,
   localparam int ROM_AW    = ROM_TOP_W + ROM_BASE_W + OFFS_W,
   localparam int LOCAL_AW  = OFFS_W + 1,
   localparam int PHYS_W    = (COMMON_AW > ROM_AW)
                              ? ((COMMON_AW > LOCAL_AW) ? COMMON_AW : LOCAL_AW)
                              : ((ROM_AW > LOCAL_AW) ? ROM_AW : LOCAL_AW),
   localparam int CS_W      = 2 + (1 << CHIP_W)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NCPU-1:0][ADDR_W-1:0]      cpu_addr,
   input  logic [NCPU-1:0]                  cpu_wr,
   input  logic [NCPU-1:0][1:0]             cpu_reg,
   input  logic [NCPU-1:0][CTRL_W-1:0]      cpu_wdata,
   output logic [NCPU-1:0][CS_W-1:0]        chip_sel,
   output logic [NCPU-1:0][PHYS_W-1:0]      phys_addr
);
   // master byte layout
   localparam int M_CHIP1_LSB = CHIP_W;
   localparam int M_TOP0_LSB  = 2 * CHIP_W;
   localparam int M_TOP1_LSB  = 2 * CHIP_W + ROM_TOP_W;
   localparam int M_USED      = 2 * CHIP_W + 2 * ROM_TOP_W - 1;

   generate
      if (ROM_BASE_W + BASE_W > CTRL_W) begin : g_bad_a
         $error("first control byte cannot hold both bases");
      end
      if (BASE_W + 1 > CTRL_W) begin : g_bad_b
         $error("second control byte cannot hold base and switch");
      end
      if (M_USED > CTRL_W) begin : g_bad_m
         $error("master byte too narrow for its fields");
      end
      if (ROM_TOP_W < 2) begin : g_bad_top
         $error("forced ROM top bit needs at least two top bits");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("address too narrow for four slots");
      end
   endgenerate

   logic [NCPU-1:0][CTRL_W-1:0]    bank_a, bank_b;
   logic [CTRL_W-1:0]              master;
   logic [NCPU-1:0][CHIP_W-1:0]    chip;
   logic [NCPU-1:0][ROM_TOP_W-1:0] rom_top;

   slot_master_reg #(.CTRL_W(CTRL_W)) u_master (
      .clk        (clk),
      .rst        (rst),
      .own_wr     (cpu_wr[0]),
      .own_code   (cpu_reg[0]),
      .own_wdata  (cpu_wdata[0]),
      .other_wr   (cpu_wr[1]),
      .other_code (cpu_reg[1]),
      .master     (master)
   );

   assign chip[0]    = master[CHIP_W-1:0];
   assign chip[1]    = master[M_CHIP1_LSB +: CHIP_W];
   assign rom_top[0] = master[M_TOP0_LSB +: ROM_TOP_W];
   assign rom_top[1] = {1'b0, master[M_TOP1_LSB +: ROM_TOP_W-1]};

   generate
      for (genvar c = 0; c < NCPU; c++) begin : g_cpu
         slot_bank_regs #(.CTRL_W(CTRL_W)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .wr     (cpu_wr[c]),
            .code   (cpu_reg[c]),
            .wdata  (cpu_wdata[c]),
            .bank_a (bank_a[c]),
            .bank_b (bank_b[c])
         );

         slot_decode #(
            .ADDR_W     (ADDR_W),
            .CTRL_W     (CTRL_W),
            .BASE_W     (BASE_W),
            .ROM_BASE_W (ROM_BASE_W),
            .CHIP_W     (CHIP_W),
            .ROM_TOP_W  (ROM_TOP_W),
            .PHYS_W     (PHYS_W),
            .CS_W       (CS_W),
            .FORCE_TOP  (c == 1)
         ) u_dec (
            .clk     (clk),
            .rst     (rst),
            .addr    (cpu_addr[c]),
            .bank_a  (bank_a[c]),
            .bank_b  (bank_b[c]),
            .chip    (chip[c]),
            .rom_top (rom_top[c]),
            .cs      (chip_sel[c]),
            .phys    (phys_addr[c])
         );
      end
   endgenerate

   p_second_rom_top_r6: assert property (@(posedge clk) disable iff (rst)
      chip_sel[1][CS_W-1] |-> phys_addr[1][ROM_AW-1]);

   p_flex_local_default_r3: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[0][ADDR_W-1 -: 2] == 2'd1 && !bank_b[0][CTRL_W-1])
      |-> chip_sel[0][CS_LOCAL]);
endmodule

// File: tb/slot_xlat_test.sv
`timescale 1ns/1ps
module slot_xlat_test;
   logic clk = 1'b0;
   logic rst;
   logic [1:0][15:0] cpu_addr;
   logic [1:0]       cpu_wr;
   logic [1:0][1:0]  cpu_reg;
   logic [1:0][7:0]  cpu_wdata;
   logic [1:0][5:0]  chip_sel;
   logic [1:0][18:0] phys_addr;

   logic [7:0] m_a [2];
   logic [7:0] m_b [2];
   logic [7:0] m_m;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   slot_xlat uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata),
      .chip_sel(chip_sel), .phys_addr(phys_addr)
   );

   function automatic logic [24:0] model(int cpu, logic [15:0] a);
      logic [5:0]  cs;
      logic [18:0] ph;
      logic [1:0]  ch;
      logic [1:0]  top;
      ch  = (cpu == 1) ? m_m[3:2] : m_m[1:0];
      top = (cpu == 1) ? {1'b1, m_m[6]} : m_m[5:4];
      case (a[15:14])
         2'd0: begin cs = 6'b000001; ph = 19'(a[14:0]); end
         2'd1: if (m_b[cpu][7]) begin
                  cs = 6'(2 << ch); ph = {m_a[cpu][4:0], a[13:0]};
               end else begin
                  cs = 6'b000001; ph = 19'(a[14:0]);
               end
         2'd2: begin cs = 6'(2 << ch); ph = {m_b[cpu][4:0], a[13:0]}; end
         default: begin cs = 6'b100000; ph = {top, m_a[cpu][7:5], a[13:0]}; end
      endcase
      return {cs, ph};
   endfunction

   function automatic string tag_for(int cpu, logic [15:0] a);
      case (a[15:14])
         2'd0: return "R2";
         2'd1: return "R3";
         2'd2: return "R4";
         default: return (cpu == 1) ? "R6" : "R5";
      endcase
   endfunction

   task automatic probe(logic [15:0] a, string tag);
      logic [15:0] av [2];
      logic [24:0] e;
      av[0] = a;
      av[1] = a ^ 16'h2A5B;
      cpu_addr[0] = av[0];
      cpu_addr[1] = av[1];
      #1;
      for (int c = 0; c < 2; c++) begin
         e = model(c, av[c]);
         checks++;
         if ({chip_sel[c], phys_addr[c]} !== e) begin
            errors++;
            $display("FAIL %s/%s cpu%0d addr %h: cs %b phys %h expected cs %b phys %h",
                     tag, tag_for(c, av[c]), c, av[c], chip_sel[c], phys_addr[c],
                     e[24:19], e[18:0]);
         end
         checks++;
         if ($countones(chip_sel[c]) != 1) begin
            errors++;
            $display("FAIL R9 cpu%0d addr %h: cs %b expected one-hot", c, av[c], chip_sel[c]);
         end
      end
   endtask

   task automatic wr_both(logic [1:0] code0, logic [7:0] d0, logic [1:0] code1, logic [7:0] d1,
                          logic en0, logic en1);
      @(negedge clk);
      cpu_wr    = {en1, en0};
      cpu_reg   = {code1, code0};
      cpu_wdata = {d1, d0};
      @(negedge clk);
      cpu_wr = '0;
      if (en0 && code0 == 2'd0) m_a[0] = d0;
      if (en0 && code0 == 2'd1) m_b[0] = d0;
      if (en0 && code0 == 2'd2) m_m    = d0;
      if (en1 && code1 == 2'd0) m_a[1] = d1;
      if (en1 && code1 == 2'd1) m_b[1] = d1;
   endtask

   task automatic sweep(string tag);
      for (int k = 0; k < 64; k++)
         probe(16'(k * 16'h0400 + ((k * 37) % 16'h0400)), tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cpu_addr = '0; cpu_wr = '0; cpu_reg = '0; cpu_wdata = '0;
      m_a[0] = '0; m_a[1] = '0; m_b[0] = '0; m_b[1] = '0; m_m = '0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state across all slots
      sweep("R1");

      // R2..R6, R9: sweep chip, bases, switch
      for (int ch = 0; ch < 4; ch++) begin
         for (int b = 0; b < 32; b++) begin
            wr_both(2'd0, {3'(b), 5'(b)}, 2'd0, {3'(7 - b % 8), 5'(31 - b)}, 1'b1, 1'b1);
            wr_both(2'd1, {b[0], 2'b00, 5'(31 - b)}, 2'd1, {~b[0], 2'b00, 5'(b)}, 1'b1, 1'b1);
            wr_both(2'd2, {1'b1, ch[0] ^ b[1], 2'(ch), 2'(3 - ch), 2'(ch)}, 2'd3, 8'h00, 1'b1, 1'b0);
            sweep("R7");
         end
      end

      // R8: write is invisible before the edge, visible after
      wr_both(2'd1, 8'h00, 2'd1, 8'h00, 1'b1, 1'b1);
      probe(16'h9234, "R8");
      @(negedge clk);
      cpu_wr = 2'b01; cpu_reg = {2'd3, 2'd1}; cpu_wdata = {8'hFF, 8'h1D};
      probe(16'h9234, "R8");
      @(negedge clk);
      cpu_wr = '0;
      m_b[0] = 8'h1D;
      probe(16'h9234, "R8");
      probe(16'h5000, "R8");

      // R7: CPU 1 master write and code-3 writes are ignored
      wr_both(2'd3, 8'hFF, 2'd2, 8'hFF, 1'b1, 1'b1);
      sweep("R7");
      wr_both(2'd3, 8'hAA, 2'd3, 8'h55, 1'b1, 1'b1);
      sweep("R7");

      // R1: reset again clears everything
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_a[0] = '0; m_a[1] = '0; m_b[0] = '0; m_b[1] = '0; m_m = '0;
      sweep("R1");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule